// File: doc/BRIEF.md
# Oscillator Divider Pair Search

This block picks a divider pair for a programmable clock oscillator whose output path runs through a high-speed divider stage and then an output divider N1. Before starting, other logic works out the range of total divide ratios that keeps the internal oscillator in its legal band. It then sends the lower and upper bounds of that range with a one-cycle start pulse. The block scans candidate total dividers upward from the lower bound. For each candidate it tries a fixed table of high-speed divider values, in table order. It keeps the first pair whose quotient N1 is an exact integer equal to 1 or even.

The result holds steady on the outputs from one done pulse to the next. It contains the chosen high-speed divider and N1, together with the codes that a control register would hold for them. An error flag shows that no candidate up to the upper bound gave a legal pair, or that the bounds were inverted.

No divider sits in the loop. Each table entry has a tracker that keeps the smallest multiple of its divider at or above the current candidate, together with the matching quotient. One entry is tested per clock by an equality compare.

Top module: `osc_div_search`

## Requirements
- R1: Candidate total dividers are scanned in ascending order, from the lower bound up to and including the upper bound. The first candidate that has any legal pair is the one reported.
- R2: For one candidate, the high-speed divider values are tried in the order 4, 5, 6, 7, 9, 11, and the first legal entry is reported. The values 8 and 10 are never reported.
- R3: A pair is legal only when the candidate is an exact multiple of the high-speed divider and the quotient N1 is either 1 or even.
- R4: When no candidate in the range has a legal pair, done is raised with err_o = 1, and hs_val_o, hs_code_o, n1_val_o and n1_code_o are all 0.
- R5: hs_code_o (3 bits) equals the reported high-speed divider minus 4.
- R6: n1_code_o is 0 when N1 is 1, and N1 minus 1 otherwise.
- R7: done_o is high for exactly one cycle per accepted search. All result outputs keep their values until the next done pulse.
- R8: A start pulse that arrives while a search is running is ignored. The running search finishes with the result for its own bounds and raises done only once.
- R9: When the lower bound exceeds the upper bound, done_o and err_o are high in the first cycle after the start edge.
- R10: A start pulse that arrives in the same cycle that done_o is high is accepted and begins a new search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a search (one-cycle pulse) |
| lo_i | input | DIV_W | Lower bound of total divider |
| hi_i | input | DIV_W | Upper bound of total divider |
| hs_val_o | output | 4 | Selected high-speed divider |
| hs_code_o | output | 3 | Register code of the high-speed divider |
| n1_val_o | output | DIV_W | Selected output divider N1 |
| n1_code_o | output | DIV_W | Register code of N1 |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | No legal pair, or inverted bounds |

## Verification
Two functions can coincide: the done pulse that ends one search, and the acceptance of a new start pulse. The bench waits for done and, in that same cycle, drives start with new bounds. It then expects a second done that carries the result for the new bounds, so the handover must leave no stale state in the trackers or the bounds. A second case raises start deep inside a long search. There the bench expects a single done that carries the first bounds' result, which separates an ignored start from an accepted one.

// File: rtl/osc_div_pkg.sv
package osc_div_pkg;

  localparam int HS_COUNT = 6;
  localparam int HS_IDX_W = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEEK = 2'd1,
    ST_TEST = 2'd2
  } srch_state_t;

  // allowed high-speed divider values, in scan order
  function automatic logic [3:0] hs_entry(input int idx);
    case (idx)
      0:       hs_entry = 4'd4;
      1:       hs_entry = 4'd5;
      2:       hs_entry = 4'd6;
      3:       hs_entry = 4'd7;
      4:       hs_entry = 4'd9;
      default: hs_entry = 4'd11;
    endcase
  endfunction

endpackage

// File: rtl/odsearch_tracker.sv
// Keeps the smallest multiple of HS that is >= the current candidate,
// with the matching quotient. Steps by one multiple per clock when behind.
module odsearch_tracker #(
  parameter int DIV_W = 12,
  parameter int HS    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [DIV_W-1:0] cand_i,
  output logic [DIV_W:0]   mult_o,
  output logic [DIV_W-1:0] quot_o,
  output logic             ready_o
);

  localparam logic [DIV_W:0]   HS_EXT = (DIV_W+1)'(HS);
  localparam logic [DIV_W-1:0] Q_ONE  = DIV_W'(1);

  logic [DIV_W:0]   mult_q;
  logic [DIV_W-1:0] quot_q;
  logic             behind;

  assign behind = mult_q < {1'b0, cand_i};

  always_ff @(posedge clk) begin
    if (rst || load_i) begin
      mult_q <= HS_EXT;
      quot_q <= Q_ONE;
    end else if (step_i && behind) begin
      mult_q <= mult_q + HS_EXT;
      quot_q <= quot_q + Q_ONE;
    end
  end

  assign mult_o  = mult_q;
  assign quot_o  = quot_q;
  assign ready_o = !behind;

  // R1: outside a reload the tracked multiple never moves down
  a_r1_mult_monotonic: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> (mult_q >= $past(mult_q)));

  // R3: one step advances exactly one multiple
  a_r3_step_size: assert property (@(posedge clk) disable iff (rst)
    (!load_i && step_i && behind) |=> (mult_q == $past(mult_q) + HS_EXT));

endmodule

// File: rtl/odsearch_ctrl.sv
module odsearch_ctrl
  import osc_div_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           start_i,
  input  logic [DIV_W-1:0]               lo_i,
  input  logic [DIV_W-1:0]               hi_i,
  input  logic [HS_COUNT-1:0][DIV_W:0]   mult_i,
  input  logic [HS_COUNT-1:0][DIV_W-1:0] quot_i,
  input  logic [HS_COUNT-1:0]            ready_i,
  output logic                           load_o,
  output logic                           step_o,
  output logic [DIV_W-1:0]               cand_o,
  output logic [3:0]                     hs_val_o,
  output logic [2:0]                     hs_code_o,
  output logic [DIV_W-1:0]               n1_val_o,
  output logic [DIV_W-1:0]               n1_code_o,
  output logic                           done_o,
  output logic                           err_o
);

  localparam logic [HS_IDX_W-1:0] LAST_IDX = HS_IDX_W'(HS_COUNT - 1);
  localparam logic [DIV_W-1:0]    ONE      = DIV_W'(1);

  srch_state_t         state_q;
  logic [DIV_W-1:0]    cand_q;
  logic [DIV_W-1:0]    hi_q;
  logic [HS_IDX_W-1:0] idx_q;
  logic [3:0]          hs_val_q;
  logic [2:0]          hs_code_q;
  logic [DIV_W-1:0]    n1_val_q;
  logic [DIV_W-1:0]    n1_code_q;
  logic                done_q;
  logic                err_q;

  logic             accept;
  logic             all_ready;
  logic [DIV_W:0]   sel_mult;
  logic [DIV_W-1:0] sel_quot;
  logic             hit;
  logic [3:0]       sel_hs;

  assign accept    = (state_q == ST_IDLE) && start_i;
  assign all_ready = &ready_i;
  assign sel_mult  = mult_i[idx_q];
  assign sel_quot  = quot_i[idx_q];
  assign hit       = (sel_mult == {1'b0, cand_q}) &&
                     ((sel_quot == ONE) || !sel_quot[0]);
  assign sel_hs    = hs_entry(int'(idx_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      cand_q    <= '0;
      hi_q      <= '0;
      idx_q     <= '0;
      hs_val_q  <= '0;
      hs_code_q <= '0;
      n1_val_q  <= '0;
      n1_code_q <= '0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            cand_q <= lo_i;
            hi_q   <= hi_i;
            idx_q  <= '0;
            if (lo_i > hi_i) begin
              done_q    <= 1'b1;
              err_q     <= 1'b1;
              hs_val_q  <= '0;
              hs_code_q <= '0;
              n1_val_q  <= '0;
              n1_code_q <= '0;
            end else begin
              state_q <= ST_SEEK;
            end
          end
        end
        ST_SEEK: begin
          if (all_ready) begin
            state_q <= ST_TEST;
            idx_q   <= '0;
          end
        end
        ST_TEST: begin
          if (hit) begin
            state_q   <= ST_IDLE;
            done_q    <= 1'b1;
            err_q     <= 1'b0;
            hs_val_q  <= sel_hs;
            hs_code_q <= 3'(sel_hs - 4'd4);
            n1_val_q  <= sel_quot;
            n1_code_q <= (sel_quot == ONE) ? '0 : sel_quot - ONE;
          end else if (idx_q == LAST_IDX) begin
            if (cand_q == hi_q) begin
              state_q   <= ST_IDLE;
              done_q    <= 1'b1;
              err_q     <= 1'b1;
              hs_val_q  <= '0;
              hs_code_q <= '0;
              n1_val_q  <= '0;
              n1_code_q <= '0;
            end else begin
              cand_q  <= cand_q + ONE;
              state_q <= ST_SEEK;
            end
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign load_o    = accept;
  assign step_o    = (state_q == ST_SEEK);
  assign cand_o    = cand_q;
  assign hs_val_o  = hs_val_q;
  assign hs_code_o = hs_code_q;
  assign n1_val_o  = n1_val_q;
  assign n1_code_o = n1_code_q;
  assign done_o    = done_q;
  assign err_o     = err_q;

  // R7: completion is a single-cycle pulse
  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R8: bounds latched for a running search do not change
  a_r8_bounds_locked: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE) |=> $stable(hi_q));

  // R1: candidates never go down during a search
  a_r1_cand_upward: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE) |=> (cand_q >= $past(cand_q)));

  // R9: inverted bounds answer with error on the next cycle
  a_r9_inverted_err: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_IDLE) && start_i && (lo_i > hi_i)) |=> (done_q && err_q));

  // R3: a reported N1 is 1 or even
  a_r3_n1_legal: assert property (@(posedge clk) disable iff (rst)
    (done_q && !err_q) |-> ((n1_val_q == ONE) || !n1_val_q[0]));

  // R6: the N1 code of an even N1 is odd
  a_r6_n1_code_odd: assert property (@(posedge clk) disable iff (rst)
    (done_q && !err_q && (n1_val_q != ONE)) |-> n1_code_q[0]);

  // R4: an error clears the result fields
  a_r4_err_zero: assert property (@(posedge clk) disable iff (rst)
    (done_q && err_q) |-> ((hs_val_q == 4'd0) && (n1_val_q == '0)));

  // R2: 8 and 10 are never selected
  a_r2_hs_table: assert property (@(posedge clk) disable iff (rst)
    (done_q && !err_q) |-> ((hs_val_q != 4'd8) && (hs_val_q != 4'd10) &&
                            (hs_val_q >= 4'd4) && (hs_val_q <= 4'd11)));

endmodule

// File: rtl/osc_div_search.sv
module osc_div_search
  import osc_div_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [DIV_W-1:0] lo_i,
  input  logic [DIV_W-1:0] hi_i,
  output logic [3:0]       hs_val_o,
  output logic [2:0]       hs_code_o,
  output logic [DIV_W-1:0] n1_val_o,
  output logic [DIV_W-1:0] n1_code_o,
  output logic             done_o,
  output logic             err_o
);

  logic [HS_COUNT-1:0][DIV_W:0]   mult;
  logic [HS_COUNT-1:0][DIV_W-1:0] quot;
  logic [HS_COUNT-1:0]            ready;
  logic                           load;
  logic                           step;
  logic [DIV_W-1:0]               cand;

  for (genvar g = 0; g < HS_COUNT; g++) begin : g_trk
    odsearch_tracker #(
      .DIV_W (DIV_W),
      .HS    (int'(hs_entry(g)))
    ) trk_i (
      .clk     (clk),
      .rst     (rst),
      .load_i  (load),
      .step_i  (step),
      .cand_i  (cand),
      .mult_o  (mult[g]),
      .quot_o  (quot[g]),
      .ready_o (ready[g])
    );
  end

  odsearch_ctrl #(
    .DIV_W (DIV_W)
  ) ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .lo_i      (lo_i),
    .hi_i      (hi_i),
    .mult_i    (mult),
    .quot_i    (quot),
    .ready_i   (ready),
    .load_o    (load),
    .step_o    (step),
    .cand_o    (cand),
    .hs_val_o  (hs_val_o),
    .hs_code_o (hs_code_o),
    .n1_val_o  (n1_val_o),
    .n1_code_o (n1_code_o),
    .done_o    (done_o),
    .err_o     (err_o)
  );

endmodule

// File: tb/osc_div_search_tb.sv
module osc_div_search_tb_top;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start_i = 1'b0;
  logic [W-1:0] lo_i = '0;
  logic [W-1:0] hi_i = '0;
  logic [3:0]   hs_val_o;
  logic [2:0]   hs_code_o;
  logic [W-1:0] n1_val_o;
  logic [W-1:0] n1_code_o;
  logic         done_o;
  logic         err_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  osc_div_search #(.DIV_W(W)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .lo_i(lo_i), .hi_i(hi_i),
    .hs_val_o(hs_val_o), .hs_code_o(hs_code_o), .n1_val_o(n1_val_o),
    .n1_code_o(n1_code_o), .done_o(done_o), .err_o(err_o)
  );

  function automatic int tbl(input int i);
    case (i)
      0: return 4; 1: return 5; 2: return 6;
      3: return 7; 4: return 9; default: return 11;
    endcase
  endfunction

  // reference: ascending candidates, table order, N1 == 1 or even
  task automatic ref_model(input int lo, input int hi,
                           output bit ok, output int hs, output int n1);
    ok = 0; hs = 0; n1 = 0;
    for (int c = lo; c <= hi && !ok; c++) begin
      for (int i = 0; i < 6 && !ok; i++) begin
        if (c != 0 && c % tbl(i) == 0 &&
            (c / tbl(i) == 1 || (c / tbl(i)) % 2 == 0)) begin
          ok = 1; hs = tbl(i); n1 = c / tbl(i);
        end
      end
    end
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_done(output int cyc);
    cyc = 1;
    while (!done_o && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    if (!done_o) chk("watchdog done", 0, 1);
  endtask

  task automatic pulse_start(input int lo, input int hi);
    lo_i = W'(lo); hi_i = W'(hi); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic check_result(input string req, input int lo, input int hi);
    bit ok; int hs, n1;
    ref_model(lo, hi, ok, hs, n1);
    chk({req, " err"}, int'(err_o), ok ? 0 : 1);
    chk({req, " hs"}, int'(hs_val_o), hs);
    chk({req, " n1"}, int'(n1_val_o), n1);
    chk({req, " R5 hs_code"}, int'(hs_code_o), ok ? hs - 4 : 0);
    chk({req, " R6 n1_code"}, int'(n1_code_o), (!ok || n1 == 1) ? 0 : n1 - 1);
  endtask

  task automatic run(input string req, input int lo, input int hi);
    int cyc;
    pulse_start(lo, hi);
    wait_done(cyc);
    check_result(req, lo, hi);
    @(negedge clk);
    chk("R7 done single", int'(done_o), 0);
    check_result("R7 hold", lo, hi);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("reset done", int'(done_o), 0);
    chk("reset err", int'(err_o), 0);
    chk("reset hs", int'(hs_val_o), 0);

    // directed cases
    run("R2 first entry 4", 8, 8);
    run("R2 odd quotient skips to 6", 12, 12);
    run("R3 n1 one at 11", 11, 11);
    run("R1 scan to second candidate", 13, 14);
    run("R4 no pair", 13, 13);
    run("R4 top of range", 255, 255);
    run("R1 near max", 250, 255);

    // R9: inverted bounds, one cycle
    pulse_start(20, 10);
    chk("R9 done next cycle", int'(done_o), 1);
    chk("R9 err", int'(err_o), 1);
    @(negedge clk);
    chk("R9 done single", int'(done_o), 0);

    // R8: start during a search is ignored
    pulse_start(101, 101);
    repeat (4) @(negedge clk);
    pulse_start(8, 8);
    wait_done(cyc);
    check_result("R8 ignored start", 101, 101);
    repeat (40) @(negedge clk);
    chk("R8 no second done", int'(done_o), 0);

    // R10: start in the done cycle is accepted
    pulse_start(60, 62);
    wait_done(cyc);
    check_result("R10 first", 60, 62);
    pulse_start(13, 14);
    chk("R10 done dropped", int'(done_o), 0);
    wait_done(cyc);
    check_result("R10 second", 13, 14);
    @(negedge clk);

    // sweep: R1 R2 R3 R4 over small ranges
    for (int lo = 0; lo < 64; lo++) begin
      for (int hi = lo - 1; hi <= lo + 8; hi++) begin
        if (hi >= 0) run("R1 R2 R3 R4 sweep", lo, hi);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule